// File: doc/BRIEF.md
# Configurable Macrocell Register Stage

This block is the output stage of one programmable-logic cell. Five product terms from an upstream AND array arrive on `pt_i`, together with a cascade sum from the neighbouring cell. A static configuration word selects three things. The first is which terms are summed. The second is how the sum is inverted or mixed with a term. The third is what the storage element captures. The storage element can behave as a D, toggle, JK or set/reset register, or as a transparent latch. The block drives a pin value with its enable, a buried feedback bit and a cascade sum for the next cell.

All logic runs on one fabric clock `clk`. The three global clocks and the term clock are level inputs that the block samples on that clock. A rising transition of the selected source, seen between two consecutive fabric samples, is a register *tick*. The stored bit changes on the fabric edge that sees the tick. Clear, preset and an open latch act combinationally on the visible register value. Their effect is then written into the stored bit on the next fabric edge. The stored bit is the block's only state, with two values, HELD0 and HELD1. Its transitions are TICK (mode function applied), OPEN (latch follows data), CLEAR (to HELD0, highest priority), PRESET (to HELD1) and RESET (to HELD0 from `rst_n`).

Fixed product-term roles: term 0 is the XOR operand and the output-enable term. Term 1 is the alternate data and the second register input (K or R). Term 2 is the term clock and the clock enable. Term 3 is the clear term and term 4 is the preset term.

Top module: `mc_macrocell`

## Requirements
- R1: `cas_o` equals the OR of every `pt_i[i]` whose `cfg_sum_mask[i]` is 1, ORed with `cas_i` when `cfg_cas_en` is 1.
- R2: The logic value is the sum for `cfg_xor_sel` 0 or 3, the inverted sum for 1, and the sum XOR `pt_i[0]` for 2.
- R3: Register data is the logic value for `cfg_dsrc` 0 or 3, `pt_i[1]` for 1, and `pin_i` for 2.
- R4: On a tick, `cfg_mode` 0 (and 5 to 7) loads data. Mode 1 toggles when data is 1. Mode 2 is JK with J = data and K = `pt_i[1]`. Mode 3 is set/reset with S = data and R = `pt_i[1]`, where R wins.
- R5: `cfg_clk_sel` 0 to 2 picks `gclk_i[n]` and 3 picks `pt_i[2]`. A tick is the selected source sampled 1 after being sampled 0 on the previous fabric edge, and the stored bit updates on that same edge. Unselected sources have no effect.
- R6: With a global clock and `cfg_ce_en` = 1, ticks and latch opening are ignored while `pt_i[2]` is 0. With the term clock, `cfg_ce_en` has no effect.
- R7: `cfg_mode` 4 is a latch. While the selected source is 1 (and the enable allows it), the register value follows data in the same cycle, and it holds while the source is 0.
- R8: `cfg_clr_sel` 0 is off, 1 is `gclr_i`, 2 is `pt_i[3]` and 3 is their OR. An active clear forces the register value to 0 at once, and the value stays 0 afterwards.
- R9: With `cfg_pre_en` = 1, `pt_i[4]` forces the register value to 1 at once. Clear wins over preset.
- R10: `pin_o` shows the register value when `cfg_out_reg` = 1, else the logic value. `fb_o` makes the same choice independently from `cfg_fb_reg`.
- R11: `pin_oe` is 0 for `cfg_oe_sel` 0, 1 for 1, `goe_i[0]` for 2, `goe_i[1]` for 3, `pt_i[0]` for 4, and 0 for 5 to 7.
- R12: While `rst_n` is 0, the stored bit is 0 and the clock history reads as all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_i | input | NUM_PT | Product terms |
| cas_i | input | 1 | Cascade sum from neighbour |
| gclk_i | input | NUM_GCLK | Global clock levels |
| gclr_i | input | 1 | Global clear |
| goe_i | input | 2 | Global output enables |
| pin_i | input | 1 | Pin input value |
| cfg_sum_mask | input | NUM_PT | Terms taken into the sum |
| cfg_cas_en | input | 1 | Add cascade input to sum |
| cfg_xor_sel | input | 2 | Second XOR operand |
| cfg_dsrc | input | 2 | Register data source |
| cfg_mode | input | 3 | Register behaviour |
| cfg_clk_sel | input | SEL_W | Register clock source |
| cfg_ce_en | input | 1 | Term 2 as clock enable |
| cfg_clr_sel | input | 2 | Clear source |
| cfg_pre_en | input | 1 | Term 4 as preset |
| cfg_out_reg | input | 1 | Pin shows register value |
| cfg_fb_reg | input | 1 | Feedback shows register value |
| cfg_oe_sel | input | 3 | Output enable source |
| pin_o | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| fb_o | output | 1 | Buried feedback |
| cas_o | output | 1 | Cascade sum to neighbour |

## Verification
A corrupted stored bit shows on `fb_o` and `pin_o` within the same cycle, whenever either is configured as registered. The bench compares those ports against its model every cycle, so a bad update appears one fabric cycle after the faulty tick. A wrong clock history does not show on the register value at once. It produces a missing or extra tick, and that becomes visible one cycle after the next transition of the selected source. Faults in the clear or preset priority show in the same cycle as the offending term, because both act combinationally on the register value.

// File: rtl/mc_pkg.sv
package mc_pkg;

    // Fixed product-term roles
    localparam int PT_XOR = 0;
    localparam int PT_OE  = 0;
    localparam int PT_AUX = 1;
    localparam int PT_CLK = 2;
    localparam int PT_CLR = 3;
    localparam int PT_PRE = 4;
    localparam int NUM_GOE = 2;

    typedef enum logic [2:0] {
        MODE_D     = 3'd0,
        MODE_T     = 3'd1,
        MODE_JK    = 3'd2,
        MODE_SR    = 3'd3,
        MODE_LATCH = 3'd4,
        MODE_RSV5  = 3'd5,
        MODE_RSV6  = 3'd6,
        MODE_RSV7  = 3'd7
    } reg_mode_e;

    typedef enum logic [1:0] {
        XOR_ZERO = 2'd0,
        XOR_ONE  = 2'd1,
        XOR_PT   = 2'd2,
        XOR_RSV  = 2'd3
    } xor_sel_e;

    typedef enum logic [1:0] {
        DSRC_LOGIC = 2'd0,
        DSRC_TERM  = 2'd1,
        DSRC_PIN   = 2'd2,
        DSRC_RSV   = 2'd3
    } dsrc_e;

    typedef enum logic [1:0] {
        CLR_OFF    = 2'd0,
        CLR_GLOBAL = 2'd1,
        CLR_TERM   = 2'd2,
        CLR_BOTH   = 2'd3
    } clr_sel_e;

    typedef enum logic [2:0] {
        OE_OFF  = 3'd0,
        OE_ON   = 3'd1,
        OE_G0   = 3'd2,
        OE_G1   = 3'd3,
        OE_TERM = 3'd4,
        OE_RSV5 = 3'd5,
        OE_RSV6 = 3'd6,
        OE_RSV7 = 3'd7
    } oe_sel_e;

endpackage

// File: rtl/mc_sum_xor.sv
module mc_sum_xor
    import mc_pkg::*;
#(
    parameter int NUM_PT = 5
) (
    input  logic [NUM_PT-1:0] pt,
    input  logic [NUM_PT-1:0] sum_mask,
    input  logic              cas_in,
    input  logic              cas_en,
    input  xor_sel_e          xor_sel,
    output logic              sum,
    output logic              logic_out
);

    logic [NUM_PT-1:0] gated;

    generate
        for (genvar i = 0; i < NUM_PT; i++) begin : g_gate
            assign gated[i] = pt[i] & sum_mask[i];
        end
    endgenerate

    always_comb begin
        sum = (|gated) | (cas_en & cas_in);
        unique case (xor_sel)
            XOR_ZERO: logic_out = sum;
            XOR_ONE:  logic_out = ~sum;
            XOR_PT:   logic_out = sum ^ pt[PT_XOR];
            default:  logic_out = sum;
        endcase
    end

endmodule

// File: rtl/mc_clk_ctrl.sv
module mc_clk_ctrl
    import mc_pkg::*;
#(
    parameter int NUM_GCLK = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_GCLK-1:0]  gclk,
    input  logic                 pt_clk,
    input  logic [$clog2(NUM_GCLK+1)-1:0] clk_sel,
    input  logic                 ce_en,
    input  logic                 gclr,
    input  logic                 pt_clr,
    input  clr_sel_e             clr_sel,
    input  logic                 pt_pre,
    input  logic                 pre_en,
    output logic                 tick,
    output logic                 gate_open,
    output logic                 clr_act,
    output logic                 pre_act
);

    localparam int NUM_SRC = NUM_GCLK + 1;
    localparam int SEL_W   = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] hist_q;
    logic               lvl;
    logic               was_hi;
    logic               use_term;
    logic               ce_ok;

    // Clock history register: level of every source at the last fabric edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {pt_clk, gclk};
    end

    always_comb begin
        lvl      = pt_clk;
        was_hi   = hist_q[NUM_GCLK];
        use_term = 1'b1;
        for (int i = 0; i < NUM_GCLK; i++) begin
            if (clk_sel == SEL_W'(i)) begin
                lvl      = gclk[i];
                was_hi   = hist_q[i];
                use_term = 1'b0;
            end
        end
        ce_ok     = use_term | ~ce_en | pt_clk;
        tick      = lvl & ~was_hi & ce_ok;
        gate_open = lvl & ce_ok;
        unique case (clr_sel)
            CLR_OFF:    clr_act = 1'b0;
            CLR_GLOBAL: clr_act = gclr;
            CLR_TERM:   clr_act = pt_clr;
            CLR_BOTH:   clr_act = gclr | pt_clr;
            default:    clr_act = 1'b0;
        endcase
        pre_act = pre_en & pt_pre;
    end

endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  reg_mode_e mode,
    input  logic      d,
    input  logic      aux,
    input  logic      tick,
    input  logic      gate_open,
    input  logic      clr_act,
    input  logic      pre_act,
    output logic      q,
    output logic      q_stored
);

    logic q_reg;
    logic q_eff;
    logic edge_val;
    logic q_next;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_reg <= 1'b0;
        else        q_reg <= q_next;
    end

    // Next-state and output process
    always_comb begin
        q_eff = q_reg;
        if (mode == MODE_LATCH && gate_open) q_eff = d;
        if (pre_act) q_eff = 1'b1;
        if (clr_act) q_eff = 1'b0;

        unique case (mode)
            MODE_T:  edge_val = q_reg ^ d;
            MODE_JK: edge_val = (d & ~q_reg) | (~aux & q_reg);
            MODE_SR: edge_val = aux ? 1'b0 : (d ? 1'b1 : q_reg);
            default: edge_val = d;
        endcase

        if (mode == MODE_LATCH) q_next = q_eff;
        else if (clr_act)       q_next = 1'b0;
        else if (pre_act)       q_next = 1'b1;
        else if (tick)          q_next = edge_val;
        else                    q_next = q_reg;
    end

    assign q        = q_eff;
    assign q_stored = q_reg;

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (q_reg == 1'b0)); // R8

    AST_PRESET_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_act && !clr_act) |=> (q_reg == 1'b1)); // R9

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_LATCH && !tick && !clr_act && !pre_act) |=> $stable(q_reg)); // R5

    AST_D_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_D && tick && !clr_act && !pre_act) |=> (q_reg == $past(d))); // R4

    AST_T_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_T && tick && d && !clr_act && !pre_act) |=> (q_reg != $past(q_reg))); // R4

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_PT   = 5,
    parameter int NUM_GCLK = 3,
    localparam int SEL_W   = $clog2(NUM_GCLK + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PT-1:0]   pt_i,
    input  logic                cas_i,
    input  logic [NUM_GCLK-1:0] gclk_i,
    input  logic                gclr_i,
    input  logic [NUM_GOE-1:0]  goe_i,
    input  logic                pin_i,
    input  logic [NUM_PT-1:0]   cfg_sum_mask,
    input  logic                cfg_cas_en,
    input  logic [1:0]          cfg_xor_sel,
    input  logic [1:0]          cfg_dsrc,
    input  logic [2:0]          cfg_mode,
    input  logic [SEL_W-1:0]    cfg_clk_sel,
    input  logic                cfg_ce_en,
    input  logic [1:0]          cfg_clr_sel,
    input  logic                cfg_pre_en,
    input  logic                cfg_out_reg,
    input  logic                cfg_fb_reg,
    input  logic [2:0]          cfg_oe_sel,
    output logic                pin_o,
    output logic                pin_oe,
    output logic                fb_o,
    output logic                cas_o
);

    reg_mode_e mode;
    dsrc_e     dsrc;
    oe_sel_e   oe_sel;

    logic sum;
    logic logic_val;
    logic reg_d;
    logic tick;
    logic gate_open;
    logic clr_act;
    logic pre_act;
    logic q;
    logic q_stored;

    assign mode   = reg_mode_e'(cfg_mode);
    assign dsrc   = dsrc_e'(cfg_dsrc);
    assign oe_sel = oe_sel_e'(cfg_oe_sel);

    mc_sum_xor #(.NUM_PT(NUM_PT)) u_sum (
        .pt        (pt_i),
        .sum_mask  (cfg_sum_mask),
        .cas_in    (cas_i),
        .cas_en    (cfg_cas_en),
        .xor_sel   (xor_sel_e'(cfg_xor_sel)),
        .sum       (sum),
        .logic_out (logic_val)
    );

    mc_clk_ctrl #(.NUM_GCLK(NUM_GCLK)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .gclk      (gclk_i),
        .pt_clk    (pt_i[PT_CLK]),
        .clk_sel   (cfg_clk_sel),
        .ce_en     (cfg_ce_en),
        .gclr      (gclr_i),
        .pt_clr    (pt_i[PT_CLR]),
        .clr_sel   (clr_sel_e'(cfg_clr_sel)),
        .pt_pre    (pt_i[PT_PRE]),
        .pre_en    (cfg_pre_en),
        .tick      (tick),
        .gate_open (gate_open),
        .clr_act   (clr_act),
        .pre_act   (pre_act)
    );

    mc_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .d         (reg_d),
        .aux       (pt_i[PT_AUX]),
        .tick      (tick),
        .gate_open (gate_open),
        .clr_act   (clr_act),
        .pre_act   (pre_act),
        .q         (q),
        .q_stored  (q_stored)
    );

    always_comb begin
        unique case (dsrc)
            DSRC_LOGIC: reg_d = logic_val;
            DSRC_TERM:  reg_d = pt_i[PT_AUX];
            DSRC_PIN:   reg_d = pin_i;
            default:    reg_d = logic_val;
        endcase

        unique case (oe_sel)
            OE_OFF:  pin_oe = 1'b0;
            OE_ON:   pin_oe = 1'b1;
            OE_G0:   pin_oe = goe_i[0];
            OE_G1:   pin_oe = goe_i[1];
            OE_TERM: pin_oe = pt_i[PT_OE];
            default: pin_oe = 1'b0;
        endcase

        pin_o = cfg_out_reg ? q : logic_val;
        fb_o  = cfg_fb_reg  ? q : logic_val;
        cas_o = sum;
    end

    AST_CE_BLOCKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_clk_sel) < NUM_GCLK && cfg_ce_en && !pt_i[PT_CLK] &&
         mode != MODE_LATCH && !clr_act && !pre_act) |=> $stable(q_stored)); // R6

endmodule

// File: tb/tb_mc_macrocell.sv
`timescale 1ns/1ps
module tb_mc_macrocell;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] pt_i = '0;
    logic       cas_i = 1'b0;
    logic [2:0] gclk_i = '0;
    logic       gclr_i = 1'b0;
    logic [1:0] goe_i = '0;
    logic       pin_i = 1'b0;
    logic [4:0] cfg_sum_mask = '0;
    logic       cfg_cas_en = 1'b0;
    logic [1:0] cfg_xor_sel = '0;
    logic [1:0] cfg_dsrc = '0;
    logic [2:0] cfg_mode = '0;
    logic [1:0] cfg_clk_sel = '0;
    logic       cfg_ce_en = 1'b0;
    logic [1:0] cfg_clr_sel = '0;
    logic       cfg_pre_en = 1'b0;
    logic       cfg_out_reg = 1'b1;
    logic       cfg_fb_reg = 1'b1;
    logic [2:0] cfg_oe_sel = 3'd1;
    logic       pin_o, pin_oe, fb_o, cas_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    bit       m_q;
    bit [3:0] m_prev;
    bit e_sum, e_lv, e_d, e_lvl, e_ceok, e_clr, e_pre, e_qe, e_pin, e_fb, e_oe;

    always #2 clk = ~clk;

    mc_macrocell dut (
        .clk(clk), .rst_n(rst_n), .pt_i(pt_i), .cas_i(cas_i), .gclk_i(gclk_i),
        .gclr_i(gclr_i), .goe_i(goe_i), .pin_i(pin_i), .cfg_sum_mask(cfg_sum_mask),
        .cfg_cas_en(cfg_cas_en), .cfg_xor_sel(cfg_xor_sel), .cfg_dsrc(cfg_dsrc),
        .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel), .cfg_ce_en(cfg_ce_en),
        .cfg_clr_sel(cfg_clr_sel), .cfg_pre_en(cfg_pre_en), .cfg_out_reg(cfg_out_reg),
        .cfg_fb_reg(cfg_fb_reg), .cfg_oe_sel(cfg_oe_sel), .pin_o(pin_o),
        .pin_oe(pin_oe), .fb_o(fb_o), .cas_o(cas_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_comb();
        bit use_term;
        e_sum = (|(pt_i & cfg_sum_mask)) | (cfg_cas_en & cas_i);
        if (cfg_xor_sel == 2'd1)      e_lv = !e_sum;
        else if (cfg_xor_sel == 2'd2) e_lv = e_sum ^ pt_i[0];
        else                          e_lv = e_sum;
        if (cfg_dsrc == 2'd1)      e_d = pt_i[1];
        else if (cfg_dsrc == 2'd2) e_d = pin_i;
        else                       e_d = e_lv;
        use_term = (cfg_clk_sel == 2'd3);
        e_lvl  = use_term ? pt_i[2] : gclk_i[cfg_clk_sel];
        e_ceok = use_term || !cfg_ce_en || pt_i[2];
        e_clr  = (cfg_clr_sel == 2'd1 && gclr_i) || (cfg_clr_sel == 2'd2 && pt_i[3]) ||
                 (cfg_clr_sel == 2'd3 && (gclr_i || pt_i[3]));
        e_pre  = cfg_pre_en && pt_i[4];
        if (e_clr)                                     e_qe = 0;
        else if (e_pre)                                e_qe = 1;
        else if (cfg_mode == 3'd4 && e_lvl && e_ceok)  e_qe = e_d;
        else                                           e_qe = m_q;
        e_pin = cfg_out_reg ? e_qe : e_lv;
        e_fb  = cfg_fb_reg ? e_qe : e_lv;
        case (cfg_oe_sel)
            3'd1:    e_oe = 1;
            3'd2:    e_oe = goe_i[0];
            3'd3:    e_oe = goe_i[1];
            3'd4:    e_oe = pt_i[0];
            default: e_oe = 0;
        endcase
    endtask

    task automatic model_update();
        int idx;
        bit rise;
        if (!rst_n) begin
            m_q = 0;
            m_prev = '0;
        end else begin
            idx  = (cfg_clk_sel == 2'd3) ? 3 : int'(cfg_clk_sel);
            rise = e_lvl && !m_prev[idx] && e_ceok;
            if (cfg_mode == 3'd4) m_q = e_qe;
            else if (e_clr)       m_q = 0;
            else if (e_pre)       m_q = 1;
            else if (rise) begin
                case (cfg_mode)
                    3'd1:    m_q = m_q ^ e_d;
                    3'd2:    m_q = (e_d && !m_q) || (!pt_i[1] && m_q);
                    3'd3:    m_q = pt_i[1] ? 0 : (e_d ? 1 : m_q);
                    default: m_q = e_d;
                endcase
            end
            m_prev = {pt_i[2], gclk_i};
        end
    endtask

    // Inputs are set just after a rising edge; outputs are compared mid-cycle.
    task automatic step(input string tag);
        #1;
        model_comb();
        chk(tag, "pin_o", pin_o, e_pin);
        chk(tag, "fb_o", fb_o, e_fb);
        chk("R11", "pin_oe", pin_oe, e_oe);
        chk("R1", "cas_o", cas_o, e_sum);
        @(posedge clk);
        model_update();
        #0.5;
    endtask

    task automatic cfg_base();
        cfg_sum_mask = 5'b00011; cfg_cas_en = 0; cfg_xor_sel = 0; cfg_dsrc = 2'd2;
        cfg_mode = 0; cfg_clk_sel = 0; cfg_ce_en = 0; cfg_clr_sel = 0; cfg_pre_en = 0;
        cfg_out_reg = 1; cfg_fb_reg = 1; cfg_oe_sel = 3'd1;
        pt_i = '0; cas_i = 0; gclk_i = '0; gclr_i = 0; goe_i = '0; pin_i = 0;
    endtask

    // Pseudo-random data inputs; clear inputs only when allowed
    task automatic run(input string tag, input int n, input bit allow_clr);
        for (int k = 0; k < n; k++) begin
            pt_i   = 5'($urandom);
            cas_i  = 1'($urandom);
            gclk_i = 3'($urandom);
            goe_i  = 2'($urandom);
            pin_i  = 1'($urandom);
            gclr_i = allow_clr ? 1'($urandom) : 1'b0;
            if (!allow_clr) pt_i[4:3] = 2'b00;
            step(tag);
        end
    endtask

    task automatic pulse(input string tag, input int sel_src);
        if (sel_src == 3) pt_i[2] = 1; else gclk_i[sel_src] = 1;
        step(tag);
        if (sel_src == 3) pt_i[2] = 0; else gclk_i[sel_src] = 0;
        step(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        m_q = 0; m_prev = '0;
        cfg_base();
        // R12: reset holds the stored bit at 0
        @(posedge clk); #0.5;
        pin_i = 1; gclk_i = 3'b111;
        repeat (3) step("R12");
        gclk_i = '0; pin_i = 0;
        step("R12");
        rst_n = 1;
        step("R12");

        // R1: sum of masked terms and cascade
        cfg_out_reg = 0; cfg_fb_reg = 0;
        for (int m = 0; m < 32; m += 5) begin
            cfg_sum_mask = 5'(m); cfg_cas_en = m[0];
            run("R1", 12, 0);
        end
        // R2: polarity and term XOR
        for (int x = 0; x < 4; x++) begin
            cfg_xor_sel = 2'(x); cfg_sum_mask = 5'b10101;
            run("R2", 16, 0);
        end
        cfg_out_reg = 1; cfg_fb_reg = 1;

        // R3: register data sources, clocked by global clock 0
        for (int s = 0; s < 4; s++) begin
            cfg_dsrc = 2'(s);
            for (int k = 0; k < 6; k++) begin
                pin_i = k[0]; pt_i[1] = k[1]; pt_i[0] = 1'(k >> 2);
                pulse("R3", 0);
            end
        end

        // R4: every register behaviour with pin data and term 1 as second input
        cfg_dsrc = 2'd2;
        for (int md = 0; md < 8; md++) begin
            if (md == 4) continue;
            cfg_mode = 3'(md);
            for (int k = 0; k < 8; k++) begin
                pin_i = k[0]; pt_i[1] = k[1];
                pulse("R4", 0);
                pulse("R4", 0);
            end
            run("R4", 20, 0);
        end

        // R5: clock source selection; unselected sources must not clock
        cfg_mode = 0;
        for (int c = 0; c < 4; c++) begin
            cfg_clk_sel = 2'(c);
            pin_i = 1; pulse("R5", c);
            pin_i = 0; pulse("R5", (c + 1) % 4);
            pin_i = 0; pulse("R5", c);
            pin_i = 1; pulse("R5", (c + 2) % 4);
            run("R5", 24, 0);
        end

        // R6: clock enable gating on global clocks, ignored on term clock
        cfg_ce_en = 1; cfg_clk_sel = 0;
        pin_i = 1; pt_i[2] = 0; pulse("R6", 0);
        pt_i[2] = 1; pulse("R6", 0);
        pin_i = 0; pt_i[2] = 0; pulse("R6", 1);
        cfg_clk_sel = 1; pulse("R6", 1);
        cfg_clk_sel = 3; pin_i = 0; pulse("R6", 3);
        for (int c = 0; c < 4; c++) begin
            cfg_clk_sel = 2'(c);
            run("R6", 30, 0);
        end
        cfg_ce_en = 0;

        // R7: transparent latch
        cfg_mode = 3'd4; cfg_clk_sel = 0;
        gclk_i[0] = 1; pin_i = 1; step("R7");
        pin_i = 0; step("R7");
        pin_i = 1; step("R7");
        gclk_i[0] = 0; pin_i = 0; step("R7");
        step("R7");
        cfg_ce_en = 1; run("R7", 40, 0); cfg_ce_en = 0;
        run("R7", 40, 0);

        // R8: clear sources
        cfg_mode = 0; cfg_pre_en = 0;
        for (int cs = 0; cs < 4; cs++) begin
            cfg_clr_sel = 2'(cs);
            pin_i = 1; pulse("R8", 0);
            gclr_i = 1; step("R8"); gclr_i = 0; step("R8");
            pin_i = 1; pulse("R8", 0);
            pt_i[3] = 1; step("R8"); pt_i[3] = 0; step("R8");
            run("R8", 30, 1);
        end

        // R9: preset, and clear winning over preset
        cfg_pre_en = 1; cfg_clr_sel = 2'd3;
        pin_i = 0; pulse("R9", 0);
        pt_i[4] = 1; step("R9");
        gclr_i = 1; step("R9");
        pt_i[3] = 1; gclr_i = 0; step("R9");
        pt_i = '0; step("R9");
        cfg_mode = 3'd4; run("R9", 30, 1);
        cfg_mode = 3'd1; run("R9", 30, 1);

        // R10: independent output and feedback selection
        cfg_mode = 0; cfg_clr_sel = 0; cfg_pre_en = 0;
        for (int o = 0; o < 4; o++) begin
            cfg_out_reg = o[0]; cfg_fb_reg = o[1];
            run("R10", 30, 0);
        end

        // R11: output enable sources
        for (int e = 0; e < 8; e++) begin
            cfg_oe_sel = 3'(e);
            run("R11", 12, 0);
        end

        // Mixed configurations
        for (int k = 0; k < 200; k++) begin
            cfg_sum_mask = 5'($urandom); cfg_cas_en = 1'($urandom);
            cfg_xor_sel = 2'($urandom); cfg_dsrc = 2'($urandom);
            cfg_mode = 3'($urandom); cfg_clk_sel = 2'($urandom);
            cfg_ce_en = 1'($urandom); cfg_clr_sel = 2'($urandom);
            cfg_pre_en = 1'($urandom); cfg_out_reg = 1'($urandom);
            cfg_fb_reg = 1'($urandom); cfg_oe_sel = 3'($urandom);
            run("R10", 10, 1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule